// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits in front of the write port of a byte-wide nonvolatile memory array. It watches every write event (address plus data byte) and looks for fixed address/data command patterns. A three-write arming pattern sets a protection flag and opens one page-load window. A six-write release pattern clears the flag after a write-cycle delay. Command bytes never reach the array. While the flag is set, any write outside an open window is dropped, and each drop is reported on a debug pulse.

The protection flag models a nonvolatile cell. The synchronous reset `rst` stands for the delivery state and clears the flag. The `pwr_cycle` input stands for a supply cycle: it clears all volatile state but leaves the flag as it was. While the block is unprotected, it holds back the bytes of a partial pattern. If a non-matching write breaks the pattern, those bytes are released in their original order, one per cycle, and the breaking write follows them.

Top module: `nvm_wrlock_seq`

## Requirements
- R1: The arming pattern is AA to 5555, then 55 to 2AAA, then A0 to 5555. It sets `prot_state` in the cycle after its third write. Each of its bytes raises `cmd_byte` in the cycle after that write, and none of them produces `arr_wr_en`.
- R2: Address bits above bit 14 are ignored when writes are compared with a pattern. A command byte given to D555 is treated exactly like one given to 5555.
- R3: When `prot_state` is 1 and no window is open, a write that is not a command step produces no array write, and `drop_dbg` pulses in the cycle after that write.
- R4: After arming, writes that fall in the page of the first loaded byte pass to the array in the cycle after each write, up to PAGE_BYTES of them. The page is the address bits above log2(PAGE_BYTES). A write to a different page is dropped and reported on `drop_dbg`.
- R5: A `prog_done` pulse closes an open window once at least one byte has been loaded. Writes after that are blocked again.
- R6: The release pattern is AA to 5555, 55 to 2AAA, 80 to 5555, AA to 5555, 55 to 2AAA, 20 to 5555. The flag stays set through the clock edge TWC_CYCLES-1 edges after the edge that captures the sixth write, and clears at the next edge. Writes made during this wait are dropped. After it, plain writes pass.
- R7: While unprotected, a write that does not start or continue a pattern appears on the array outputs in the next cycle, with the same address and data.
- R8: While unprotected, a non-matching write that breaks a partial pattern of k bytes causes a replay. The k held bytes, each with its original upper address bits, appear on the array outputs in cycles c+2 to c+1+k, where c is the cycle of the breaking write. The breaking write follows in cycle c+2+k.
- R9: While protected, a broken partial pattern is discarded. Neither its held bytes nor the breaking write reach the array, and the breaking write pulses `drop_dbg`.
- R10: A breaking write that is itself AA to 5555 starts a new pattern. It raises `cmd_byte` and does not raise `drop_dbg`.
- R11: `pwr_cycle` keeps `prot_state` unchanged and discards any partial pattern. `rst` clears `prot_state` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high delivery reset; clears everything, including the flag |
| pwr_cycle | input | 1 | Supply-cycle event; clears volatile state and keeps the flag |
| wr_valid | input | 1 | One-cycle write event |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| prog_done | input | 1 | Pulse: the array has finished programming a page |
| arr_wr_en | output | 1 | Registered array write strobe |
| arr_wr_addr | output | ADDR_W | Array write address |
| arr_wr_data | output | 8 | Array write data |
| cmd_byte | output | 1 | The write in the previous cycle was taken as a command step |
| prot_state | output | 1 | Protection flag |
| drop_dbg | output | 1 | The write in the previous cycle was dropped |

## Verification
The assertions assume that no write event arrives while a replay is being drained. A replay lasts at most six cycles after the breaking write, and the bench always leaves several idle cycles between writes. They also assume that `prog_done` comes only from the array and that `pwr_cycle` and `rst` are single synchronous pulses. The bench drives writes back to back only where an exact cycle count is being measured, such as the release wait, and never while a replay is running.

// File: rtl/nvmlk_pkg.sv
package nvmlk_pkg;
  localparam int CMD_AW   = 15;   // compared address bits
  localparam int BYTE_W   = 8;
  localparam int SEQ_LEN  = 6;    // release pattern length
  localparam int ENA_STEP = 2;    // step at which the arming byte branches off
  localparam logic [BYTE_W-1:0] ENA_DATA = 8'hA0;

  function automatic logic [CMD_AW-1:0] step_addr(input logic [2:0] k);
    return (k == 3'd1 || k == 3'd4) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [BYTE_W-1:0] step_data(input logic [2:0] k);
    case (k)
      3'd0, 3'd3: return 8'hAA;
      3'd1, 3'd4: return 8'h55;
      3'd2:       return 8'h80;
      default:    return 8'h20;
    endcase
  endfunction
endpackage

// File: rtl/nvmlk_match.sv
module nvmlk_match
  import nvmlk_pkg::*;
(
  input  logic [2:0]        step,
  input  logic [CMD_AW-1:0] addr_lo,
  input  logic [BYTE_W-1:0] data,
  output logic              m_cont,
  output logic              m_enab,
  output logic              m_start
);
  logic [SEQ_LEN-1:0] hit;

  for (genvar k = 0; k < SEQ_LEN; k++) begin : g_step
    assign hit[k] = (addr_lo == step_addr(3'(k))) && (data == step_data(3'(k)));
  end

  assign m_cont  = |(hit & (SEQ_LEN'(1) << step));
  assign m_start = hit[0];
  assign m_enab  = (step == 3'(ENA_STEP)) &&
                   (addr_lo == step_addr(3'(ENA_STEP))) && (data == ENA_DATA);
endmodule

// File: rtl/nvmlk_page_win.sv
module nvmlk_page_win #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 128,
  localparam int PG_LSB    = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - PG_LSB,
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            arm,
  input  logic            wr,
  input  logic [PG_W-1:0] page,
  input  logic            prog_done,
  output logic            open_q,
  output logic            accept
);
  logic [CNT_W-1:0] cnt_q;
  logic [PG_W-1:0]  page_q;

  assign accept = open_q && (cnt_q == '0 || page == page_q) &&
                  (cnt_q < CNT_W'(PAGE_BYTES));

  always_ff @(posedge clk) begin
    if (clr) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      page_q <= '0;
    end else if (arm) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
    end else if (open_q && prog_done && cnt_q != '0) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (wr && accept) begin
      cnt_q  <= cnt_q + 1'b1;
      page_q <= page;
    end
  end

  // R4: the load count never exceeds one page
  a_r4_count_cap: assert property (@(posedge clk) disable iff (clr)
    cnt_q <= CNT_W'(PAGE_BYTES));

  // R5: completion of programming closes a loaded window
  a_r5_window_close: assert property (@(posedge clk) disable iff (clr)
    (open_q && prog_done && cnt_q != '0 && !arm) |=> !open_q);
endmodule

// File: rtl/nvmlk_replay.sv
module nvmlk_replay
  import nvmlk_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int HI_W  = ADDR_W - CMD_AW
) (
  input  logic                          clk,
  input  logic                          clr,
  input  logic                          start,
  input  logic [2:0]                    start_len,
  input  logic [SEQ_LEN-2:0][HI_W-1:0]  start_hi,
  input  logic                          tail_v,
  input  logic [ADDR_W-1:0]             tail_addr,
  input  logic [BYTE_W-1:0]             tail_data,
  output logic                          busy_q,
  output logic [ADDR_W-1:0]             out_addr,
  output logic [BYTE_W-1:0]             out_data
);
  logic [2:0]                   idx_q, len_q;
  logic [SEQ_LEN-2:0][HI_W-1:0] hi_q;
  logic                         tv_q;
  logic [ADDR_W-1:0]            taddr_q;
  logic [BYTE_W-1:0]            tdata_q;
  logic [3:0]                   total;

  assign total = {1'b0, len_q} + {3'b000, tv_q};

  always_comb begin
    if (idx_q < len_q) begin
      out_addr = {hi_q[idx_q], step_addr(idx_q)};
      out_data = step_data(idx_q);
    end else begin
      out_addr = taddr_q;
      out_data = tdata_q;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      len_q   <= '0;
      hi_q    <= '0;
      tv_q    <= 1'b0;
      taddr_q <= '0;
      tdata_q <= '0;
    end else if (start) begin
      busy_q  <= (start_len != '0) || tail_v;
      idx_q   <= '0;
      len_q   <= start_len;
      hi_q    <= start_hi;
      tv_q    <= tail_v;
      taddr_q <= tail_addr;
      tdata_q <= tail_data;
    end else if (busy_q) begin
      if ({1'b0, idx_q} + 4'd1 == total) busy_q <= 1'b0;
      idx_q <= idx_q + 1'b1;
    end
  end

  // R8: a replay with held bytes starts draining in the following cycle
  a_r8_replay_starts: assert property (@(posedge clk) disable iff (clr)
    (start && start_len != '0) |=> busy_q);
endmodule

// File: rtl/nvm_wrlock_seq.sv
module nvm_wrlock_seq
  import nvmlk_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 128,
  parameter int TWC_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_cycle,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              prog_done,
  output logic              arr_wr_en,
  output logic [ADDR_W-1:0] arr_wr_addr,
  output logic [BYTE_W-1:0] arr_wr_data,
  output logic              cmd_byte,
  output logic              prot_state,
  output logic              drop_dbg
);
  localparam int HI_W   = ADDR_W - CMD_AW;
  localparam int PG_LSB = $clog2(PAGE_BYTES);
  localparam int TMR_W  = $clog2(TWC_CYCLES + 1);

  logic                         flag_q, pend_q;
  logic [TMR_W-1:0]             tmr_q;
  logic [2:0]                   seq_q;
  logic [SEQ_LEN-2:0][HI_W-1:0] held_hi_q;
  logic                         clr_vol;

  logic m_cont, m_enab, m_start;
  logic win_open, win_accept;
  logic rp_busy;
  logic [ADDR_W-1:0] rp_addr;
  logic [BYTE_W-1:0] rp_data;

  logic go, act_win, act_pend, act_seq, take_cmd, done_en, done_dis;
  logic brk, restart, pass_direct, drop, cmd_hit, start_rp, tail_v;

  assign clr_vol = rst || pwr_cycle;

  nvmlk_match i_match (
    .step    (seq_q),
    .addr_lo (wr_addr[CMD_AW-1:0]),
    .data    (wr_data),
    .m_cont  (m_cont),
    .m_enab  (m_enab),
    .m_start (m_start)
  );

  // Write classification
  always_comb begin
    go          = wr_valid && !rp_busy;
    act_win     = go && win_open;
    act_pend    = go && !win_open && pend_q;
    act_seq     = go && !win_open && !pend_q;
    take_cmd    = act_seq && (m_cont || m_enab);
    done_en     = act_seq && m_enab;
    done_dis    = act_seq && m_cont && (seq_q == 3'(SEQ_LEN - 1));
    brk         = act_seq && !take_cmd && (seq_q != '0);
    restart     = brk && m_start;
    start_rp    = brk && !flag_q;
    tail_v      = brk && !restart && !flag_q;
    pass_direct = (act_win && win_accept) ||
                  (act_seq && !take_cmd && (seq_q == '0) && !flag_q);
    drop        = (act_win && !win_accept) || act_pend ||
                  (act_seq && !take_cmd && !restart && flag_q);
    cmd_hit     = take_cmd || restart;
  end

  nvmlk_page_win #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) i_win (
    .clk       (clk),
    .clr       (clr_vol),
    .arm       (done_en),
    .wr        (act_win),
    .page      (wr_addr[ADDR_W-1:PG_LSB]),
    .prog_done (prog_done),
    .open_q    (win_open),
    .accept    (win_accept)
  );

  nvmlk_replay #(.ADDR_W(ADDR_W)) i_replay (
    .clk       (clk),
    .clr       (clr_vol),
    .start     (start_rp),
    .start_len (seq_q),
    .start_hi  (held_hi_q),
    .tail_v    (tail_v),
    .tail_addr (wr_addr),
    .tail_data (wr_data),
    .busy_q    (rp_busy),
    .out_addr  (rp_addr),
    .out_data  (rp_data)
  );

  // Nonvolatile flag: only the delivery reset clears it directly
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (!pwr_cycle) begin
      if (done_en) flag_q <= 1'b1;
      else if (pend_q && tmr_q == '0) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_vol) begin
      pend_q      <= 1'b0;
      tmr_q       <= '0;
      seq_q       <= '0;
      held_hi_q   <= '0;
      arr_wr_en   <= 1'b0;
      arr_wr_addr <= '0;
      arr_wr_data <= '0;
      cmd_byte    <= 1'b0;
      drop_dbg    <= 1'b0;
    end else begin
      arr_wr_en   <= rp_busy || pass_direct;
      arr_wr_addr <= rp_busy ? rp_addr : wr_addr;
      arr_wr_data <= rp_busy ? rp_data : wr_data;
      cmd_byte    <= cmd_hit;
      drop_dbg    <= drop;

      if (take_cmd) begin
        if (done_en || done_dis) seq_q <= '0;
        else begin
          seq_q <= seq_q + 1'b1;
          held_hi_q[seq_q] <= wr_addr[ADDR_W-1:CMD_AW];
        end
      end else if (restart) begin
        seq_q        <= 3'd1;
        held_hi_q[0] <= wr_addr[ADDR_W-1:CMD_AW];
      end else if (brk) begin
        seq_q <= '0;
      end

      if (done_dis) begin
        pend_q <= 1'b1;
        tmr_q  <= TMR_W'(TWC_CYCLES - 1);
      end else if (pend_q) begin
        if (tmr_q == '0) pend_q <= 1'b0;
        else tmr_q <= tmr_q - 1'b1;
      end
    end
  end

  assign prot_state = flag_q;

  // R1: a cycle that reports a command byte carries no array write
  a_r1_cmd_not_stored: assert property (@(posedge clk) disable iff (clr_vol)
    cmd_byte |-> !arr_wr_en);

  // R3: a stray write while locked is dropped and reported
  a_r3_locked_drop: assert property (@(posedge clk) disable iff (clr_vol)
    (wr_valid && !rp_busy && flag_q && !win_open && !m_cont && !m_enab && !m_start)
      |=> (!arr_wr_en && drop_dbg));

  // R6: the flag only falls at the end of a release wait (or by reset)
  a_r6_release_wait: assert property (@(posedge clk) disable iff (rst)
    $fell(prot_state) |-> ($past(pend_q) || $past(rst)));

  // R8: input rule - no write event while a replay drains
  a_r8_no_write_in_replay: assert property (@(posedge clk) disable iff (clr_vol)
    rp_busy |-> !wr_valid);
endmodule

// File: tb/test_nvm_wrlock_seq.sv
module test_nvm_wrlock_seq;
  localparam int TWC = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_cycle = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_done = 1'b0;
  logic        arr_wr_en, cmd_byte, prot_state, drop_dbg;
  logic [15:0] arr_wr_addr;
  logic [7:0]  arr_wr_data;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nvm_wrlock_seq #(.ADDR_W(16), .PAGE_BYTES(128), .TWC_CYCLES(TWC)) i_nvm_wrlock_seq (
    .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
    .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
    .cmd_byte(cmd_byte), .prot_state(prot_state), .drop_dbg(drop_dbg)
  );

  // {addr, data, exp_en, exp_cmd, exp_drop}; starts unprotected
  localparam int NV = 8;
  localparam logic [26:0] VEC [NV] = '{
    {16'h1234, 8'h5A, 3'b100},  // R7 plain write
    {16'h8123, 8'h00, 3'b100},  // R7 plain write, high bit set
    {16'h5555, 8'hAA, 3'b010},  // R1 arm step 1
    {16'h2AAA, 8'h55, 3'b010},  // R1 arm step 2
    {16'hD555, 8'hA0, 3'b010},  // R2 arm step 3 with bit 15 set
    {16'h0100, 8'h11, 3'b100},  // R4 first byte of window
    {16'h017F, 8'h22, 3'b100},  // R4 same page
    {16'h0200, 8'h33, 3'b001}   // R4 other page dropped
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    prog_done = 1'b1; @(negedge clk); prog_done = 1'b0; idle(2);
  endtask

  task automatic chk_out(input string tag, input bit en, input bit cmd, input bit drp);
    chk({tag, " en"}, 32'(arr_wr_en), 32'(en));
    chk({tag, " cmd"}, 32'(cmd_byte), 32'(cmd));
    chk({tag, " drop"}, 32'(drop_dbg), 32'(drp));
  endtask

  task automatic chk_wr(input string tag, input logic [15:0] a, input logic [7:0] d);
    chk({tag, " en"}, 32'(arr_wr_en), 32'd1);
    chk({tag, " addr"}, 32'(arr_wr_addr), 32'(a));
    chk({tag, " data"}, 32'(arr_wr_data), 32'(d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int seen;
    idle(3);
    rst = 1'b0;
    idle(1);
    // R11 reset state
    chk("R11 reset prot", 32'(prot_state), 32'd0);
    chk_out("R11 reset", 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_wr(VEC[i][26:11], VEC[i][10:3]);
      chk_out($sformatf("table row %0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
      if (VEC[i][2]) chk_wr($sformatf("table row %0d", i), VEC[i][26:11], VEC[i][10:3]);
      idle(3);
    end
    chk("R1 flag after arming", 32'(prot_state), 32'd1);

    // R5: programming done closes the window
    pulse_done();
    do_wr(16'h0101, 8'h44);
    chk_out("R5 after close", 1'b0, 1'b0, 1'b1);
    idle(3);

    // R9: broken pattern while protected is discarded
    do_wr(16'h5555, 8'hAA); chk_out("R9 step1", 1'b0, 1'b1, 1'b0); idle(3);
    do_wr(16'h2AAA, 8'h55); chk_out("R9 step2", 1'b0, 1'b1, 1'b0); idle(3);
    do_wr(16'h0033, 8'h12); chk_out("R9 breaker", 1'b0, 1'b0, 1'b1);
    seen = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (arr_wr_en) seen++; end
    chk("R9 no array write", 32'(seen), 32'd0);

    // R10: breaker that starts a new pattern
    do_wr(16'h5555, 8'hAA); chk_out("R10 step1", 1'b0, 1'b1, 1'b0); idle(3);
    do_wr(16'hD555, 8'hAA); chk_out("R10 restart", 1'b0, 1'b1, 1'b0); idle(3);
    do_wr(16'h2AAA, 8'h55); chk_out("R10 step2", 1'b0, 1'b1, 1'b0); idle(3);
    do_wr(16'h5555, 8'hA0); chk_out("R10 step3", 1'b0, 1'b1, 1'b0); idle(3);
    do_wr(16'h0305, 8'h66); chk_wr("R10 window write", 16'h0305, 8'h66); idle(3);
    pulse_done();

    // R6: release pattern and write-cycle wait
    do_wr(16'h5555, 8'hAA); chk_out("R6 s1", 1'b0, 1'b1, 1'b0); idle(2);
    do_wr(16'h2AAA, 8'h55); chk_out("R6 s2", 1'b0, 1'b1, 1'b0); idle(2);
    do_wr(16'h5555, 8'h80); chk_out("R6 s3", 1'b0, 1'b1, 1'b0); idle(2);
    do_wr(16'hD555, 8'hAA); chk_out("R6 s4", 1'b0, 1'b1, 1'b0); idle(2);
    do_wr(16'h2AAA, 8'h55); chk_out("R6 s5", 1'b0, 1'b1, 1'b0); idle(2);
    do_wr(16'h5555, 8'h20); chk_out("R6 s6", 1'b0, 1'b1, 1'b0);
    chk("R6 flag right after", 32'(prot_state), 32'd1);
    do_wr(16'h0400, 8'h01); chk_out("R6 write during wait", 1'b0, 1'b0, 1'b1);
    idle(TWC - 2);
    chk("R6 flag at last wait edge", 32'(prot_state), 32'd1);
    idle(1);
    chk("R6 flag cleared", 32'(prot_state), 32'd0);
    do_wr(16'h0400, 8'h02); chk_wr("R6 unrestricted write", 16'h0400, 8'h02);
    idle(3);

    // R8: replay of a broken partial pattern while unprotected
    do_wr(16'hD555, 8'hAA); chk_out("R8 h1", 1'b0, 1'b1, 1'b0); idle(3);
    do_wr(16'h2AAA, 8'h55); chk_out("R8 h2", 1'b0, 1'b1, 1'b0); idle(3);
    do_wr(16'h5555, 8'h80); chk_out("R8 h3", 1'b0, 1'b1, 1'b0); idle(3);
    do_wr(16'h0044, 8'h77); chk_out("R8 breaker cycle", 1'b0, 1'b0, 1'b0);
    @(negedge clk); chk_wr("R8 replay 0", 16'hD555, 8'hAA);
    @(negedge clk); chk_wr("R8 replay 1", 16'h2AAA, 8'h55);
    @(negedge clk); chk_wr("R8 replay 2", 16'h5555, 8'h80);
    @(negedge clk); chk_wr("R8 replay tail", 16'h0044, 8'h77);
    @(negedge clk); chk("R8 replay end", 32'(arr_wr_en), 32'd0);
    idle(3);

    // R11: supply cycle keeps the flag, drops the partial pattern
    do_wr(16'h5555, 8'hAA); idle(2);
    do_wr(16'h2AAA, 8'h55); idle(2);
    do_wr(16'h5555, 8'hA0); idle(2);
    do_wr(16'h0500, 8'h01); idle(2);
    pulse_done();
    do_wr(16'h5555, 8'hAA); chk_out("R11 partial", 1'b0, 1'b1, 1'b0); idle(2);
    pwr_cycle = 1'b1; @(negedge clk); pwr_cycle = 1'b0; idle(1);
    chk("R11 flag kept", 32'(prot_state), 32'd1);
    do_wr(16'h2AAA, 8'h55); chk_out("R11 partial discarded", 1'b0, 1'b0, 1'b1);
    idle(2);
    rst = 1'b1; @(negedge clk); rst = 1'b0; idle(1);
    chk("R11 delivery reset flag", 32'(prot_state), 32'd0);
    do_wr(16'h0600, 8'h99); chk_wr("R11 write after reset", 16'h0600, 8'h99);
    idle(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule